// File: doc/BRIEF.md
# GPIO Pad Controller with Event Interrupts

This block controls a parameterised set of general-purpose pads through a small synchronous 32-bit register port. Each pad owns one configuration word. The word holds the level the pad drives, a read-only view of the pad's synchronised input, an input-inversion control and a two-bit event selector. Every pad input passes through a two-flop synchroniser. After optional inversion, the block watches it for a level, a rising edge or either edge.

Detected events are recorded in 32-bit status words, one bit per pad, and software clears them by writing ones. A parallel set of enable words masks the recorded events. A single registered interrupt line is asserted while any pad has both its status bit and its enable bit set. Software typically configures the pads, enables the ones it cares about, and on an interrupt reads and clears the status words.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: Pad n's configuration word sits at byte address 0x600 + 16·n. Bit 0 is the drive value, bit 1 the synchronised input (read-only), bit 23 the inversion control and bits 26:25 the event selector. Every other bit reads zero.
- R2: Bit 0 of pad n's word appears on pad_out[n] in the cycle after the write. Bit 1 shows pad_in[n] two clocks after the input changes, and writes to bit 1 have no effect.
- R3: With bit 23 set, the pad input is inverted before event detection, so a low input counts as active.
- R4: Selector 00 (level) sets the status bit on every clock while the active input is high. A clear issued while the input stays active leaves the bit set.
- R5: Selector 01 sets the status bit only when the active input goes from low to high.
- R6: Selector 11 sets the status bit on every change of the active input, in either direction.
- R7: Selector 10 sets no status bit, whatever the input does, while bit 1 still tracks the input.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a clear and a new event for the same pad fall in the same cycle, the bit ends up set.
- R9: Status bits latch whether or not the matching enable bit is set. The interrupt output goes high one clock after a status bit and its enable bit are both set.
- R10: Configuration addresses for pads at or beyond NUM_PADS read as zero and ignore writes, and so do misaligned or unmapped addresses.
- R11: Pad n's status bit is bit n%32 of the word at 0x100 + 4·(n/32), and its enable bit is bit n%32 of the word at 0x110 + 4·(n/32). Bits for pads at or beyond NUM_PADS read zero.
- R12: Reset clears every configuration, status and enable bit and drives pad_out and irq low.
- R13: An input change sets the status bit three clocks later: two synchroniser stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at addr (combinational) |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Pad drive values |
| irq | output | 1 | Combined registered interrupt |

## Verification
A stuck or wrongly updated status bit shows up in the status word three clocks after the input edge that should have set it. It appears on irq one clock after that, once the pad's enable bit is set. A lost or surviving history flop shows as an extra or missing edge event at the first input change after the mode is chosen. The bench lines each check up with those latencies, so a mistake is seen within four clocks of the stimulus that exposes it. An address decode error shows in the very read that follows the write.

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int NUM_PADS = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [11:0]         addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic                irq
);

  localparam int NBANK  = (NUM_PADS + 31) / 32;
  localparam int PW     = NBANK * 32;
  localparam int PIDX_W = $clog2(NUM_PADS);
  localparam logic [7:0] CFG_ROW = 8'h60;
  localparam logic [7:0] STS_ROW = 8'h10;
  localparam logic [7:0] EN_ROW  = 8'h11;
  localparam logic [1:0] EV_LEVEL = 2'b00;
  localparam logic [1:0] EV_RISE  = 2'b01;
  localparam logic [1:0] EV_OFF   = 2'b10;
  localparam logic [1:0] EV_BOTH  = 2'b11;

  logic [NUM_PADS-1:0] drv, inv, sync1, sync2, act_q, sts, en;
  logic [NUM_PADS-1:0] act, evt, clr;
  logic [NUM_PADS-1:0][1:0] mode;
  logic [PW-1:0] sts_w, en_w;
  logic [7:0] row_off;
  logic [PIDX_W-1:0] pidx;
  logic is_cfg, is_sts, is_en;

  assign row_off = addr[11:4] - CFG_ROW;
  assign pidx    = row_off[PIDX_W-1:0];
  assign is_cfg  = (addr[11:4] >= CFG_ROW) && (int'(row_off) < NUM_PADS) && (addr[3:0] == 4'd0);
  assign is_sts  = (addr[11:4] == STS_ROW) && (addr[1:0] == 2'd0) && (int'(addr[3:2]) < NBANK);
  assign is_en   = (addr[11:4] == EN_ROW)  && (addr[1:0] == 2'd0) && (int'(addr[3:2]) < NBANK);

  assign act     = sync2 ^ inv;
  assign pad_out = drv;
  assign sts_w   = PW'(sts);
  assign en_w    = PW'(en);

  always_comb begin
    for (int i = 0; i < NUM_PADS; i++) begin
      case (mode[i])
        EV_LEVEL: evt[i] = act[i];
        EV_RISE:  evt[i] = act[i] & ~act_q[i];
        EV_BOTH:  evt[i] = act[i] ^ act_q[i];
        default:  evt[i] = 1'b0;
      endcase
      clr[i] = wr_en && is_sts && (addr[3:2] == 2'(i / 32)) && wdata[i % 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv   <= '0;
      inv   <= '0;
      mode  <= '0;
      sync1 <= '0;
      sync2 <= '0;
      act_q <= '0;
      sts   <= '0;
      en    <= '0;
      irq   <= 1'b0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      act_q <= act;
      sts   <= (sts & ~clr) | evt;
      irq   <= |(sts & en);
      if (wr_en && is_cfg) begin
        drv[pidx]  <= wdata[0];
        inv[pidx]  <= wdata[23];
        mode[pidx] <= wdata[26:25];
      end
      for (int i = 0; i < NUM_PADS; i++)
        if (wr_en && is_en && (addr[3:2] == 2'(i / 32)))
          en[i] <= wdata[i % 32];
    end
  end

  always_comb begin
    rdata = '0;
    if (is_cfg) begin
      rdata[0]     = drv[pidx];
      rdata[1]     = sync2[pidx];
      rdata[23]    = inv[pidx];
      rdata[26:25] = mode[pidx];
    end
    for (int b = 0; b < NBANK; b++) begin
      if (is_sts && (addr[3:2] == 2'(b))) rdata = sts_w[b*32 +: 32];
      if (is_en  && (addr[3:2] == 2'(b))) rdata = en_w[b*32 +: 32];
    end
  end

  // R8: a status bit only ever drops after a status-word write
  a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sts) & ~sts)) |-> $past(wr_en && is_sts));

  // R2: pad drive only moves after a configuration write
  a_r2_drive_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_cfg) |=> $stable(pad_out));

  // R9: irq rises only after some status bit was pending
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|sts));

  // R10: addresses past the last pad read zero
  a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= 'h600 + 16 * NUM_PADS) |-> (rdata == 32'd0));

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad_chk
    // R7: no status bit is raised by a pad in the disabled mode
    a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[g]) |-> ($past(mode[g]) != EV_OFF));
    // R4: active level always leaves the status bit set next cycle
    a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[g] == EV_LEVEL && act[g]) |=> sts[g]);
  end

endmodule

// File: tb/gpio_pad_ctrl_test.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_test;

  localparam int NP = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pad_ctrl #(.NUM_PADS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
  );

  // {address, write data, expected readback}
  localparam logic [75:0] VEC [10] = '{
    {12'h600, 32'h02000001, 32'h02000001},   // R1
    {12'h610, 32'hF97FFFFE, 32'h00000000},   // R1 unused bits and R2 read-only bit
    {12'h650, 32'h04800000, 32'h04800000},   // R1
    {12'hAF0, 32'h02000001, 32'h02000001},   // R1 last pad
    {12'hB00, 32'hFFFFFFFF, 32'h00000000},   // R10 pad 80
    {12'h604, 32'hFFFFFFFF, 32'h00000000},   // R10 misaligned
    {12'h110, 32'hA5A5A5A5, 32'hA5A5A5A5},   // R11
    {12'h118, 32'hFFFFFFFF, 32'h0000FFFF},   // R11 upper bits absent
    {12'h11C, 32'hFFFFFFFF, 32'h00000000},   // R10 bank 3 absent
    {12'h100, 32'hFFFFFFFF, 32'h00000000}    // R8 nothing pending
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();

    // R12 reset state
    chk("R12 pad_out", 32'(pad_out[31:0]), 32'd0);
    chk("R12 irq", 32'(irq), 32'd0);
    rd(12'h630, v); chk("R12 cfg", v, 32'd0);
    rd(12'h100, v); chk("R12 status", v, 32'd0);

    for (int k = 0; k < 10; k++) begin
      wr(VEC[k][75:64], VEC[k][63:32]);
      rd(VEC[k][75:64], v);
      chk("R1/R10/R11 table", v, VEC[k][31:0]);
    end
    chk("R2 pad_out0", 32'(pad_out[0]), 32'd1);
    chk("R2 pad_out79", 32'(pad_out[79]), 32'd1);

    do_reset();

    // R2 drive and synchronised input
    wr(12'h630, 32'h1);
    chk("R2 drive", 32'(pad_out[3]), 32'd1);
    pad_in[3] = 1'b1;
    cyc(1); rd(12'h630, v); chk("R2 input one clock", v, 32'h1);
    cyc(1); rd(12'h630, v); chk("R2 input two clocks", v, 32'h3);

    // R5 rising edge, R13 latency, R9 irq timing
    wr(12'h6A0, 32'h02000000);
    wr(12'h110, 32'h1 << 10);
    pad_in[10] = 1'b1;
    cyc(2); rd(12'h100, v); chk("R13 not yet", v & (32'h1 << 10), 32'd0);
    cyc(1); rd(12'h100, v); chk("R5 rise sets", v & (32'h1 << 10), 32'h1 << 10);
    chk("R9 irq lags", 32'(irq), 32'd0);
    cyc(1); chk("R9 irq high", 32'(irq), 32'd1);
    wr(12'h100, 32'h1 << 10);
    rd(12'h100, v); chk("R8 cleared", v & (32'h1 << 10), 32'd0);
    cyc(1); chk("R9 irq low", 32'(irq), 32'd0);
    cyc(3); rd(12'h100, v); chk("R5 held high no event", v & (32'h1 << 10), 32'd0);
    pad_in[10] = 1'b0;
    cyc(4); rd(12'h100, v); chk("R5 fall no event", v & (32'h1 << 10), 32'd0);

    // R6 both edges
    wr(12'h6B0, 32'h06000000);
    pad_in[11] = 1'b1;
    cyc(3); rd(12'h100, v); chk("R6 rise", v & (32'h1 << 11), 32'h1 << 11);
    wr(12'h100, 32'h1 << 11);
    rd(12'h100, v); chk("R8 clear both", v & (32'h1 << 11), 32'd0);
    pad_in[11] = 1'b0;
    cyc(3); rd(12'h100, v); chk("R6 fall", v & (32'h1 << 11), 32'h1 << 11);

    // R3 inversion
    wr(12'h6C0, 32'h04800000);
    cyc(2);
    wr(12'h6C0, 32'h02800000);
    cyc(3); rd(12'h100, v); chk("R3 quiet", v & (32'h1 << 12), 32'd0);
    pad_in[12] = 1'b1;
    cyc(4); rd(12'h100, v); chk("R3 high input inactive", v & (32'h1 << 12), 32'd0);
    pad_in[12] = 1'b0;
    cyc(3); rd(12'h100, v); chk("R3 low input active", v & (32'h1 << 12), 32'h1 << 12);

    // R4 level mode
    pad_in[20] = 1'b1;
    cyc(3); rd(12'h100, v); chk("R4 level sets", v & (32'h1 << 20), 32'h1 << 20);
    wr(12'h100, 32'h1 << 20);
    rd(12'h100, v); chk("R4 clear ignored while active", v & (32'h1 << 20), 32'h1 << 20);
    pad_in[20] = 1'b0;
    cyc(3);
    wr(12'h100, 32'h1 << 20);
    rd(12'h100, v); chk("R4 clear after release", v & (32'h1 << 20), 32'd0);

    // R7 disabled mode
    wr(12'h750, 32'h04000000);
    pad_in[21] = 1'b1;
    cyc(3); rd(12'h750, v); chk("R7 input visible", v, 32'h04000002);
    rd(12'h100, v); chk("R7 no event on rise", v & (32'h1 << 21), 32'd0);
    pad_in[21] = 1'b0;
    cyc(3); rd(12'h100, v); chk("R7 no event on fall", v & (32'h1 << 21), 32'd0);

    // R9 latching without enable, R11 banks
    wr(12'h880, 32'h02000000);
    pad_in[40] = 1'b1;
    cyc(4); rd(12'h104, v); chk("R11 pad40 bank1", v, 32'h1 << 8);
    chk("R9 disabled no irq", 32'(irq), 32'd0);
    wr(12'h114, 32'h1 << 8);
    chk("R9 irq after enable lag", 32'(irq), 32'd0);
    cyc(1); chk("R9 irq after enable", 32'(irq), 32'd1);
    wr(12'hA60, 32'h02000000);
    pad_in[70] = 1'b1;
    cyc(3); rd(12'h108, v); chk("R11 pad70 bank2", v, 32'h1 << 6);

    // R8 clear and event in the same cycle
    wr(12'h6D0, 32'h02000000);
    pad_in[13] = 1'b1;
    cyc(3); rd(12'h100, v); chk("R8 first event", v & (32'h1 << 13), 32'h1 << 13);
    pad_in[13] = 1'b0;
    cyc(3);
    pad_in[13] = 1'b1;
    cyc(2);
    wr(12'h100, 32'h1 << 13);
    rd(12'h100, v); chk("R8 event wins", v & (32'h1 << 13), 32'h1 << 13);
    wr(12'h100, 32'h0);
    rd(12'h100, v); chk("R8 zero write", v & (32'h1 << 13), 32'h1 << 13);
    wr(12'h100, 32'h1 << 13);
    rd(12'h100, v); chk("R8 later clear", v & (32'h1 << 13), 32'd0);

    // R10 write beyond count leaves real pads untouched
    wr(12'hB00, 32'h1);
    rd(12'hB00, v); chk("R10 pad80 read", v, 32'd0);
    chk("R10 pad79 drive", 32'(pad_out[79]), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule